// File: doc/BRIEF.md
# Write leveling sequencer

This block runs write leveling, one byte group at a time, on a DDR3 memory interface. A pulse on `start` makes it issue a mode register write that puts the memory into leveling mode. It then raises the leveling-enable output and visits each group in ascending order. For each group it clears that group's DQ and DQS output delay lines and fires leveling strobes. It samples the group's feedback bit after each strobe and moves both delay lines forward together, one tap per step, until it finds where the feedback rises from 0 to 1.

Some groups have more than one bit time of skew. Such a group already reads 1 on its first probe. The block flags it as high-skew and first steps the strobe out of that high zone until the feedback reads 0. Only then does it look for the rising edge. The tap count where the edge is found is stored per group, together with the flag. The tap budget is the maximum delay minus a half-period tap count given on an input. If a group reaches that budget, leveling stops and fails. In both cases the block leaves leveling mode with a second mode register write before it reports `done`.

Top module: `wlvl_sequencer`

## Requirements
- R1: After `start` in idle, the block issues one command with `cmd_ras`, `cmd_cas`, `cmd_we` and `cmd_cs` all 1, `cmd_bank` = 1 and `cmd_addr` = MR1_BASE with bit 7 set (0x0C6 by default). `lvl_en` goes to 1 in the cycle after that command cycle, and it was 0 in the command cycle.
- R2: When leveling ends, successfully or not, the block issues the same command form with bit 7 of `cmd_addr` clear (0x046 by default) to bank 1. `lvl_en` goes to 0 in the following cycle, and `done` is then set. Each run issues exactly two commands.
- R3: Each probe is a one-cycle `lvl_strobe`, issued only while `lvl_en` is 1. The feedback bit is captured on the clock edge that comes `settle_cycles`+2 edges after the edge on which the strobe was set. The bench treats any earlier value as unreliable.
- R4: `dq_dly_rst` and `dqs_dly_rst` pulse together once per group before its first probe. `dq_dly_inc` and `dqs_dly_inc` always pulse in the same cycles, once per step.
- R5: The tap limit is MAX_TAPS minus `half_taps`, latched at start. If a step is needed at the limit, or the edge is found at a tap at or above the limit, `fail` is set and leveling stops.
- R6: A group whose first probe reads 1 is marked in `grp_high_skew`. The block steps until the feedback reads 0 and then searches for the next 0-to-1 edge. A 1 seen while still in the high zone is never taken as the edge.
- R7: On success, group g's field `grp_delay[g*TAP_W +: TAP_W]` holds the tap at which the feedback first read 1 after reading 0. Results are cleared to 0 at start.
- R8: `busy` is 1 from the cycle after start until `done` rises. `done` and `fail` hold until the next start. A `start` pulse while busy has no effect.
- R9: Groups are visited in ascending order, with `grp_sel` = 1 << group held while the group is processed. Only the selected group's bit of `lvl_fb` affects the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a leveling run (ignored while busy) |
| half_taps | input | TAP_W | Half-period tap count subtracted from MAX_TAPS |
| settle_cycles | input | SETTLE_W | Extra wait between strobe and feedback sample |
| lvl_fb | input | NUM_GROUPS | Leveling feedback bit per group |
| cmd_valid | output | 1 | Command issue strobe |
| cmd_ras | output | 1 | Row strobe of the command |
| cmd_cas | output | 1 | Column strobe of the command |
| cmd_we | output | 1 | Write enable of the command |
| cmd_cs | output | 1 | Chip select of the command |
| cmd_addr | output | ADDR_W | Mode register value |
| cmd_bank | output | BANK_W | Mode register select |
| lvl_en | output | 1 | Leveling enable to the physical layer |
| grp_sel | output | NUM_GROUPS | One-hot group select |
| dq_dly_rst | output | 1 | Reset DQ output delay of the selected group |
| dqs_dly_rst | output | 1 | Reset DQS output delay of the selected group |
| dq_dly_inc | output | 1 | Advance DQ output delay by one tap |
| dqs_dly_inc | output | 1 | Advance DQS output delay by one tap |
| lvl_strobe | output | 1 | Leveling strobe pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Run hit the tap limit |
| grp_delay | output | NUM_GROUPS*TAP_W | Per-group final tap count |
| grp_high_skew | output | NUM_GROUPS | Per-group high-skew flag |

## Verification
Two decisions land on the same probe evaluation: finding the rising edge and hitting the tap limit. Groups are placed so that the edge sits one tap below the limit, which must pass with that tap recorded. Other groups put the edge exactly at the limit, which must fail. The bench also has the high zone run straight into the edge, so the exit from the high zone and the limit check meet in the same cycle. That case must end in failure and never in a result taken from a 1 seen while still in the high zone.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_MR_ON,
      SQ_LVL_ON,
      SQ_SEL,
      SQ_PROBE,
      SQ_WAITP,
      SQ_INC,
      SQ_MR_OFF,
      SQ_LVL_OFF,
      SQ_FIN
   } seq_state_t;

   typedef enum logic [1:0] {
      PB_IDLE,
      PB_STB,
      PB_WAIT
   } probe_state_t;

endpackage

// File: rtl/wlvl_cmd.sv
module wlvl_cmd #(
   parameter int unsigned ADDR_W   = 14,
   parameter int unsigned BANK_W   = 3,
   parameter int unsigned MR1_BASE = 'h046,
   parameter int unsigned LVL_BIT  = 7,
   parameter int unsigned MR_BANK  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_on,
   input  logic              issue_off,
   output logic              cmd_valid,
   output logic              cmd_ras,
   output logic              cmd_cas,
   output logic              cmd_we,
   output logic              cmd_cs,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [BANK_W-1:0] cmd_bank
);

   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(MR1_BASE);
   localparam logic [ADDR_W-1:0] LVL_M  = ADDR_W'(1) << LVL_BIT;
   localparam logic [BANK_W-1:0] BANK_V = BANK_W'(MR_BANK);

   if (LVL_BIT >= ADDR_W) begin : g_chk_bit
      $error("LVL_BIT outside the address field");
   end
   if (MR_BANK >= (1 << BANK_W)) begin : g_chk_bank
      $error("MR_BANK does not fit BANK_W");
   end

   logic issue;
   assign issue = issue_on | issue_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_ras   <= 1'b0;
         cmd_cas   <= 1'b0;
         cmd_we    <= 1'b0;
         cmd_cs    <= 1'b0;
         cmd_addr  <= '0;
         cmd_bank  <= '0;
      end else begin
         cmd_valid <= issue;
         cmd_ras   <= issue;
         cmd_cas   <= issue;
         cmd_we    <= issue;
         cmd_cs    <= issue;
         if (issue) begin
            cmd_addr <= issue_on ? (BASE_V | LVL_M) : (BASE_V & ~LVL_M);
            cmd_bank <= BANK_V;
         end
      end
   end

   // R1 / R2: entry and exit are never requested together
   assert_cmd_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_on && issue_off));

   // R2: a command is a single-cycle event
   assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/wlvl_probe.sv
module wlvl_probe
   import wlvl_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned SETTLE_W   = 4,
   localparam int unsigned GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [SETTLE_W-1:0]   settle,
   input  logic [GRP_W-1:0]      grp,
   input  logic [NUM_GROUPS-1:0] fb,
   output logic                  strobe,
   output logic                  smp_valid,
   output logic                  smp
);

   probe_state_t          st_q;
   logic [SETTLE_W-1:0]   cnt_q;
   logic                  fb_sel;

   if (NUM_GROUPS == 1) begin : g_single
      assign fb_sel = fb[0];
   end else begin : g_mux
      assign fb_sel = fb[grp];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PB_IDLE;
         cnt_q     <= '0;
         strobe    <= 1'b0;
         smp_valid <= 1'b0;
         smp       <= 1'b0;
      end else begin
         smp_valid <= 1'b0;
         case (st_q)
            PB_IDLE: begin
               if (go) begin
                  strobe <= 1'b1;
                  st_q   <= PB_STB;
               end
            end
            PB_STB: begin
               strobe <= 1'b0;
               cnt_q  <= settle;
               st_q   <= PB_WAIT;
            end
            PB_WAIT: begin
               if (cnt_q == '0) begin
                  smp       <= fb_sel;
                  smp_valid <= 1'b1;
                  st_q      <= PB_IDLE;
               end else begin
                  cnt_q <= cnt_q - SETTLE_W'(1);
               end
            end
            default: st_q <= PB_IDLE;
         endcase
      end
   end

   // R3: the strobe lasts one cycle
   assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   // R3: a new probe is only requested when the previous one has finished
   assert_go_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (st_q == PB_IDLE));

endmodule

// File: rtl/wlvl_results.sv
module wlvl_results #(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned TAP_W      = 6,
   localparam int unsigned GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        wr,
   input  logic [GRP_W-1:0]            grp,
   input  logic [TAP_W-1:0]            tap,
   input  logic                        hs,
   output logic [NUM_GROUPS*TAP_W-1:0] delay_flat,
   output logic [NUM_GROUPS-1:0]       hs_vec
);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
      logic hit;
      assign hit = wr && (grp == GRP_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            delay_flat[g*TAP_W +: TAP_W] <= '0;
            hs_vec[g]                    <= 1'b0;
         end else if (clr) begin
            delay_flat[g*TAP_W +: TAP_W] <= '0;
            hs_vec[g]                    <= 1'b0;
         end else if (hit) begin
            delay_flat[g*TAP_W +: TAP_W] <= tap;
            hs_vec[g]                    <= hs;
         end
      end
   end

   // R7: results are never written in the cycle they are cleared
   assert_wr_not_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !clr);

endmodule

// File: rtl/wlvl_sequencer.sv
module wlvl_sequencer
   import wlvl_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned MAX_TAPS   = 32,
   parameter int unsigned SETTLE_W   = 4,
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned BANK_W     = 3,
   parameter int unsigned MR1_BASE   = 'h046,
   localparam int unsigned TAP_W     = $clog2(MAX_TAPS + 1),
   localparam int unsigned GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [TAP_W-1:0]            half_taps,
   input  logic [SETTLE_W-1:0]         settle_cycles,
   input  logic [NUM_GROUPS-1:0]       lvl_fb,
   output logic                        cmd_valid,
   output logic                        cmd_ras,
   output logic                        cmd_cas,
   output logic                        cmd_we,
   output logic                        cmd_cs,
   output logic [ADDR_W-1:0]           cmd_addr,
   output logic [BANK_W-1:0]           cmd_bank,
   output logic                        lvl_en,
   output logic [NUM_GROUPS-1:0]       grp_sel,
   output logic                        dq_dly_rst,
   output logic                        dqs_dly_rst,
   output logic                        dq_dly_inc,
   output logic                        dqs_dly_inc,
   output logic                        lvl_strobe,
   output logic                        busy,
   output logic                        done,
   output logic                        fail,
   output logic [NUM_GROUPS*TAP_W-1:0] grp_delay,
   output logic [NUM_GROUPS-1:0]       grp_high_skew
);

   localparam logic [TAP_W-1:0] MAX_T    = TAP_W'(MAX_TAPS);
   localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

   if (NUM_GROUPS < 1) begin : g_chk_groups
      $error("NUM_GROUPS must be at least 1");
   end
   if (MAX_TAPS < 2) begin : g_chk_taps
      $error("MAX_TAPS must be at least 2");
   end
   if (SETTLE_W < 1) begin : g_chk_settle
      $error("SETTLE_W must be at least 1");
   end

   seq_state_t            st_q;
   logic [GRP_W-1:0]      grp_q;
   logic [TAP_W-1:0]      tap_q;
   logic [TAP_W-1:0]      limit_q;
   logic [TAP_W-1:0]      limit_c;
   logic [SETTLE_W-1:0]   settle_q;
   logic                  first_q;
   logic                  high_q;
   logic                  hs_q;
   logic                  rst_q;
   logic                  inc_q;
   logic                  lvl_q;
   logic                  busy_q;
   logic                  done_q;
   logic                  fail_q;
   logic [NUM_GROUPS-1:0] sel_q;

   logic probe_go;
   logic smp_valid;
   logic smp;
   logic issue_on;
   logic issue_off;
   logic at_limit;
   logic still_high;
   logic found;
   logic res_wr;
   logic res_clr;

   // tap budget, saturating at zero
   assign limit_c    = (half_taps >= MAX_T) ? '0 : (MAX_T - half_taps);

   assign probe_go   = (st_q == SQ_PROBE);
   assign issue_on   = (st_q == SQ_MR_ON);
   assign issue_off  = (st_q == SQ_MR_OFF);
   assign at_limit   = (tap_q >= limit_q);
   assign still_high = first_q ? smp : (high_q & smp);
   assign found      = !first_q && !high_q && smp;
   assign res_wr     = (st_q == SQ_WAITP) && smp_valid && found && !at_limit;
   assign res_clr    = (st_q == SQ_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         grp_q    <= '0;
         tap_q    <= '0;
         limit_q  <= '0;
         settle_q <= '0;
         first_q  <= 1'b0;
         high_q   <= 1'b0;
         hs_q     <= 1'b0;
         rst_q    <= 1'b0;
         inc_q    <= 1'b0;
         lvl_q    <= 1'b0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         fail_q   <= 1'b0;
         sel_q    <= '0;
      end else begin
         rst_q <= 1'b0;
         inc_q <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  busy_q   <= 1'b1;
                  done_q   <= 1'b0;
                  fail_q   <= 1'b0;
                  grp_q    <= '0;
                  limit_q  <= limit_c;
                  settle_q <= settle_cycles;
                  st_q     <= SQ_MR_ON;
               end
            end
            SQ_MR_ON:  st_q <= SQ_LVL_ON;
            SQ_LVL_ON: begin
               lvl_q <= 1'b1;
               st_q  <= SQ_SEL;
            end
            SQ_SEL: begin
               sel_q   <= NUM_GROUPS'(1) << grp_q;
               rst_q   <= 1'b1;
               tap_q   <= '0;
               first_q <= 1'b1;
               high_q  <= 1'b0;
               hs_q    <= 1'b0;
               st_q    <= SQ_PROBE;
            end
            SQ_PROBE: st_q <= SQ_WAITP;
            SQ_WAITP: begin
               if (smp_valid) begin
                  first_q <= 1'b0;
                  high_q  <= still_high;
                  if (first_q) begin
                     hs_q <= smp;
                  end
                  if (at_limit) begin
                     fail_q <= 1'b1;
                     st_q   <= SQ_MR_OFF;
                  end else if (found) begin
                     if (grp_q == LAST_GRP) begin
                        st_q <= SQ_MR_OFF;
                     end else begin
                        grp_q <= grp_q + GRP_W'(1);
                        st_q  <= SQ_SEL;
                     end
                  end else begin
                     st_q <= SQ_INC;
                  end
               end
            end
            SQ_INC: begin
               inc_q <= 1'b1;
               tap_q <= tap_q + TAP_W'(1);
               st_q  <= SQ_PROBE;
            end
            SQ_MR_OFF: begin
               sel_q <= '0;
               st_q  <= SQ_LVL_OFF;
            end
            SQ_LVL_OFF: begin
               lvl_q <= 1'b0;
               st_q  <= SQ_FIN;
            end
            SQ_FIN: begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               st_q   <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   wlvl_cmd #(
      .ADDR_W   (ADDR_W),
      .BANK_W   (BANK_W),
      .MR1_BASE (MR1_BASE),
      .LVL_BIT  (7),
      .MR_BANK  (1)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_on  (issue_on),
      .issue_off (issue_off),
      .cmd_valid (cmd_valid),
      .cmd_ras   (cmd_ras),
      .cmd_cas   (cmd_cas),
      .cmd_we    (cmd_we),
      .cmd_cs    (cmd_cs),
      .cmd_addr  (cmd_addr),
      .cmd_bank  (cmd_bank)
   );

   wlvl_probe #(
      .NUM_GROUPS (NUM_GROUPS),
      .SETTLE_W   (SETTLE_W)
   ) u_probe (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (probe_go),
      .settle    (settle_q),
      .grp       (grp_q),
      .fb        (lvl_fb),
      .strobe    (lvl_strobe),
      .smp_valid (smp_valid),
      .smp       (smp)
   );

   wlvl_results #(
      .NUM_GROUPS (NUM_GROUPS),
      .TAP_W      (TAP_W)
   ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (res_clr),
      .wr         (res_wr),
      .grp        (grp_q),
      .tap        (tap_q),
      .hs         (hs_q),
      .delay_flat (grp_delay),
      .hs_vec     (grp_high_skew)
   );

   assign lvl_en      = lvl_q;
   assign grp_sel     = sel_q;
   assign dq_dly_rst  = rst_q;
   assign dqs_dly_rst = rst_q;
   assign dq_dly_inc  = inc_q;
   assign dqs_dly_inc = inc_q;
   assign busy        = busy_q;
   assign done        = done_q;
   assign fail        = fail_q;

   // R1: leveling enable rises only right after a command
   assert_lvl_after_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_q) |-> $past(cmd_valid));

   // R2: leveling enable falls only right after a command
   assert_lvl_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl_q) |-> $past(cmd_valid));

   // R3: strobes only while leveling is enabled
   assert_strobe_in_lvl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_strobe |-> lvl_q);

   // R5: the tap counter never passes the latched limit
   assert_tap_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (tap_q <= limit_q));

   // R8: done and busy are never both set
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   // R9: steps and strobes act on exactly one group
   assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_q || lvl_strobe || rst_q) |-> ($countones(sel_q) == 1));

endmodule

// File: tb/wlvl_sequencer_test.sv
module wlvl_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int NG         = 4;
   localparam int MAXT       = 32;
   localparam int TW         = 6;
   localparam int SW         = 4;
   localparam int NV         = 5;
   localparam int MR1B       = 'h046;

   // stimulus and expected-result table: half taps, settle, edge tap, high-zone length
   localparam int V_HALF   [NV]     = '{8, 16, 4, 16, 8};
   localparam int V_SETTLE [NV]     = '{0, 3, 1, 2, 0};
   localparam int V_EDGE   [NV][NG] = '{'{5, 9, 3, 12}, '{7, 10, 4, 15}, '{27, 1, 20, 6},
                                        '{2, 16, 3, 4}, '{6, 5, 9, 9}};
   localparam int V_HIGH   [NV][NG] = '{'{0, 0, 0, 0}, '{3, 0, 2, 0}, '{0, 0, 10, 5},
                                        '{0, 0, 0, 0}, '{0, 5, 0, 0}};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [TW-1:0]   half_taps = '0;
   logic [SW-1:0]   settle_cycles = '0;
   logic [NG-1:0]   lvl_fb = '1;
   logic            cmd_valid, cmd_ras, cmd_cas, cmd_we, cmd_cs;
   logic [13:0]     cmd_addr;
   logic [2:0]      cmd_bank;
   logic            lvl_en;
   logic [NG-1:0]   grp_sel;
   logic            dq_dly_rst, dqs_dly_rst, dq_dly_inc, dqs_dly_inc, lvl_strobe;
   logic            busy, done, fail;
   logic [NG*TW-1:0] grp_delay;
   logic [NG-1:0]   grp_high_skew;

   wlvl_sequencer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .half_taps(half_taps),
      .settle_cycles(settle_cycles), .lvl_fb(lvl_fb), .cmd_valid(cmd_valid),
      .cmd_ras(cmd_ras), .cmd_cas(cmd_cas), .cmd_we(cmd_we), .cmd_cs(cmd_cs),
      .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .lvl_en(lvl_en), .grp_sel(grp_sel),
      .dq_dly_rst(dq_dly_rst), .dqs_dly_rst(dqs_dly_rst), .dq_dly_inc(dq_dly_inc),
      .dqs_dly_inc(dqs_dly_inc), .lvl_strobe(lvl_strobe), .busy(busy), .done(done),
      .fail(fail), .grp_delay(grp_delay), .grp_high_skew(grp_high_skew)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // model configuration, written by the main sequence only
   int m_edge [NG];
   int m_high [NG];
   int m_settle = 0;

   // monitor state, written by the monitor only
   int        cmd_cnt = 0;
   logic [13:0] c_addr [8];
   logic [2:0]  c_bank [8];
   logic [3:0]  c_flag [8];
   int        lvl_err = 0;
   int        inc_err = 0;
   int        grp_err = 0;
   int        strb_err = 0;
   int        grp_next = 0;
   int        tap_m = 0;
   int        wait_m = 0;
   logic      prev_on = 1'b0;
   logic      prev_off = 1'b0;

   function automatic int sel_index(logic [NG-1:0] s);
      int r = 0;
      for (int k = 0; k < NG; k++) if (s[k]) r = k;
      return r;
   endfunction

   function automatic logic truth(int g, int t);
      return (t < m_high[g]) || (t >= m_edge[g]);
   endfunction

   always @(posedge clk) cycles <= cycles + 1;

   // DRAM/delay-line model and protocol monitor
   always @(negedge clk) begin
      int g;
      g = sel_index(grp_sel);
      if (prev_on && !lvl_en) lvl_err++;
      if (prev_off && lvl_en) lvl_err++;
      if (cmd_valid && cmd_addr[7] && lvl_en) lvl_err++;
      prev_on  = cmd_valid && cmd_addr[7];
      prev_off = cmd_valid && !cmd_addr[7];
      if (cmd_valid) begin
         c_addr[cmd_cnt % 8] = cmd_addr;
         c_bank[cmd_cnt % 8] = cmd_bank;
         c_flag[cmd_cnt % 8] = {cmd_ras, cmd_cas, cmd_we, cmd_cs};
         cmd_cnt++;
         if (cmd_addr[7]) grp_next = 0;
      end
      if (dq_dly_inc != dqs_dly_inc) inc_err++;
      if (dq_dly_rst != dqs_dly_rst) inc_err++;
      if (dq_dly_rst) begin
         if (grp_sel != (NG'(1) << grp_next)) grp_err++;
         grp_next++;
         tap_m = 0;
      end
      if (dq_dly_inc) tap_m++;
      if (lvl_strobe) begin
         if (!lvl_en) strb_err++;
         wait_m = m_settle + 1;
         lvl_fb = '1;
         lvl_fb[g] = ~truth(g, tap_m);
      end else if (wait_m > 0) begin
         wait_m--;
         if (wait_m == 0) begin
            lvl_fb = '1;
            lvl_fb[g] = truth(g, tap_m);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic run_vec(input int v, input bit extra_start);
      int base, le, ie, ge, se, n, lim;
      bit exp_fail, stop;
      for (int g = 0; g < NG; g++) begin
         m_edge[g] = V_EDGE[v][g];
         m_high[g] = V_HIGH[v][g];
      end
      m_settle      = V_SETTLE[v];
      half_taps     = TW'(V_HALF[v]);
      settle_cycles = SW'(V_SETTLE[v]);
      base = cmd_cnt; le = lvl_err; ie = inc_err; ge = grp_err; se = strb_err;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R8 busy after start", busy, 1);
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
         start = (extra_start && n == 30);
      end
      start = 1'b0;
      check(done === 1'b1, "R8 done reached", done, 1);
      check(busy === 1'b0, "R8 busy cleared", busy, 0);
      lim = MAXT - V_HALF[v];
      exp_fail = 0; stop = 0;
      for (int g = 0; g < NG; g++) begin
         if (!stop) begin
            if (V_EDGE[v][g] > V_HIGH[v][g] && V_EDGE[v][g] < lim) begin
               check(grp_delay[g*TW +: TW] == TW'(V_EDGE[v][g]), "R7 group delay",
                     int'(grp_delay[g*TW +: TW]), V_EDGE[v][g]);
               check(grp_high_skew[g] == (V_HIGH[v][g] > 0), "R6 high skew flag",
                     int'(grp_high_skew[g]), int'(V_HIGH[v][g] > 0));
            end else begin
               exp_fail = 1;
               stop = 1;
            end
         end
      end
      check(fail === exp_fail, "R5 fail flag", fail, exp_fail);
      check(cmd_cnt - base == 2, "R2 command count", cmd_cnt - base, 2);
      check(c_addr[base % 8] == 14'(MR1B | 'h80) && c_bank[base % 8] == 3'd1 &&
            c_flag[base % 8] == 4'hF, "R1 entry command", int'(c_addr[base % 8]), MR1B | 'h80);
      check(c_addr[(base + 1) % 8] == 14'(MR1B) && c_bank[(base + 1) % 8] == 3'd1 &&
            c_flag[(base + 1) % 8] == 4'hF, "R2 exit command", int'(c_addr[(base + 1) % 8]), MR1B);
      check(lvl_err == le && lvl_en === 1'b0, "R1 R2 leveling enable timing", lvl_err - le, 0);
      check(inc_err == ie, "R4 paired delay pulses", inc_err - ie, 0);
      check(grp_err == ge, "R9 group order", grp_err - ge, 0);
      check(strb_err == se, "R3 strobe within leveling", strb_err - se, 0);
      check(grp_sel == '0, "R9 select released", int'(grp_sel), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && fail === 1'b0 && lvl_en === 1'b0,
            "R8 reset state", {busy, done, fail, lvl_en}, 0);
      check(cmd_valid === 1'b0 && grp_sel === '0 && grp_delay === '0,
            "R7 reset outputs", int'(grp_sel), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int v = 0; v < NV; v++) run_vec(v, 1'b0);
      // R8: start while busy is ignored (rerun of the first vector)
      run_vec(0, 1'b1);
      // R3: longest settle on a simple pattern
      begin
         int d;
         for (int g = 0; g < NG; g++) begin m_edge[g] = g + 2; m_high[g] = 0; end
         m_settle = 15; settle_cycles = 4'd15; half_taps = 6'd0;
         start = 1'b1; @(negedge clk); start = 1'b0;
         d = 0;
         while (!done && d < 20000) begin @(negedge clk); d++; end
         for (int g = 0; g < NG; g++)
            check(grp_delay[g*TW +: TW] == TW'(g + 2), "R3 long settle delay",
                  int'(grp_delay[g*TW +: TW]), g + 2);
         check(fail === 1'b0, "R3 long settle no fail", fail, 0);
      end
      // R8: done and fail hold while idle
      repeat (5) @(negedge clk);
      check(done === 1'b1 && busy === 1'b0, "R8 done holds", done, 1);
      summary();
   end

   initial begin
      wait (cycles > 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual %0d expected 0", cycles);
      summary();
   end

endmodule